// File: doc/BRIEF.md
# Dual-Channel Simultaneous-Sampling Converter Core

This block is the digital side of a converter that samples two analog inputs (lanes A and B) at the same instant and resolves each into a 12-bit two's complement word by successive approximation. A low-going conversion strobe freezes both inputs. On the first rising clock edge that sees the strobe low, the core captures the held samples and the channel-select address, and it raises a busy flag. It then spends sixteen clock cycles on the conversion. At the end it files the A/B result pair into a storage slot chosen by the captured address.

Results are read over a single shared 12-bit bus. The bus is modelled as data plus an output-enable, and it is enabled only while chip select and the read strobe are both low. With chip select held low, successive read strobes step through lane A and then lane B of the slot named by the live address input. The A/B pointer goes back to lane A when chip select rises or the address changes. In the bench, a pair of sample words stands in for the analog front end.

Top module: `dual_sar_core`

## Requirements
- R1: When the core is idle, `busy` goes high in the same cycle that `start_n` falls, before any clock edge.
- R2: The first rising edge of `clk` that finds `start_n` low after a high sample is conversion cycle one. `busy` stays high through sixteen cycles and is low right after the sixteenth edge that follows.
- R3: Both lane samples are taken at the cycle-one edge. Later changes on `samp_a`/`samp_b` do not alter the stored result.
- R4: `addr` is captured at the cycle-one edge, and the finished pair is written into the slot of the captured address. The slot of the other address keeps its contents.
- R5: Each lane's result is resolved MSB first (bit 11 first) and equals its two's complement sample, including 0x800, 0x7FF, 0xFFF and 0x000.
- R6: `dout_oe` is 1 only while `cs_n` and `rd_n` are both 0. While `dout_oe` is 0, `dout` reads 0.
- R7: While `cs_n` stays low, the first read strobe shows lane A of the addressed slot and the next shows lane B. The pointer moves on each rising edge of `rd_n` and wraps back to A.
- R8: A high `cs_n`, or a change of `addr`, returns the read pointer to lane A.
- R9: A fall of `start_n` while `busy` is high is ignored. It neither lengthens `busy` nor starts another conversion.
- R10: Activity on `cs_n` and `rd_n` during a conversion does not affect it.
- R11: After reset, `busy` and `dout_oe` are 0 and both slots read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Active-low conversion strobe |
| addr | input | 1 | Channel-pair select |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| samp_a | input | 12 | Lane A sample (two's complement) |
| samp_b | input | 12 | Lane B sample (two's complement) |
| busy | output | 1 | Conversion in progress |
| dout | output | 12 | Read data |
| dout_oe | output | 1 | Bus drive enable |

## Verification
The bench goes after the sample and address capture edge. It changes both inputs right after cycle one, so a core that sampled them late would store the wrong pair or write the wrong slot. A second start pulse in the middle of a conversion checks the busy length: a core that re-armed on it would keep busy high longer or start again afterwards. Extreme codes such as 0x800 and 0x7FF would show an MSB-first resolution that got the sign offset wrong. Read sequences that wrap past lane B, that change the address between strobes, and that raise chip select would catch a read pointer that does not move or does not clear.

// File: rtl/dual_sar_pkg.sv
package dual_sar_pkg;
    parameter int DATA_W      = 12;
    parameter int CONV_CYCLES = 16;   // must exceed DATA_W
    parameter int ADDR_W      = 1;
    localparam int N_ADDR     = 1 << ADDR_W;
    localparam int CNT_W      = $clog2(CONV_CYCLES + 1);
    localparam int N_LANE     = 2;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic [ADDR_W-1:0]        addr_t;
    typedef logic [CNT_W-1:0]         cnt_t;

    typedef struct packed {
        sample_t ch_a;
        sample_t ch_b;
    } pair_t;

    typedef enum logic {
        SEL_A = 1'b0,
        SEL_B = 1'b1
    } lane_e;

    localparam logic [DATA_W-1:0] SIGN_BIT = {1'b1, {(DATA_W-1){1'b0}}};

    function automatic logic [DATA_W-1:0] to_offset(sample_t s);
        return s ^ SIGN_BIT;
    endfunction

    function automatic sample_t from_offset(logic [DATA_W-1:0] u);
        return sample_t'(u ^ SIGN_BIT);
    endfunction

    function automatic sample_t pick_lane(pair_t p, lane_e l);
        return (l == SEL_B) ? p.ch_b : p.ch_a;
    endfunction
endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import dual_sar_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_n,
    input  addr_t addr,
    output logic  busy,
    output logic  begin_conv,
    output logic  finish,
    output addr_t addr_lat
);
    logic start_q;
    logic running;
    cnt_t cnt;
    logic fall_seen;

    assign fall_seen  = start_q & ~start_n;
    assign begin_conv = fall_seen & ~running;
    assign finish     = running && (cnt == cnt_t'(CONV_CYCLES));
    assign busy       = running | begin_conv;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q  <= 1'b1;
            running  <= 1'b0;
            cnt      <= '0;
            addr_lat <= '0;
        end else begin
            start_q <= start_n;
            if (begin_conv) begin
                running  <= 1'b1;
                cnt      <= cnt_t'(1);
                addr_lat <= addr;
            end else if (finish) begin
                running <= 1'b0;
                cnt     <= '0;
            end else if (running) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2: cycle one begins with the count at one
    p_begin_cycle_one_r2: assert property (@(posedge clk) disable iff (rst)
        begin_conv |=> (running && cnt == cnt_t'(1)));
    // R2: busy ends after the last cycle
    p_busy_ends_r2: assert property (@(posedge clk) disable iff (rst)
        finish |=> !running);
    // R9: a mid-conversion strobe neither restarts nor stalls the count
    p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (running && !finish) |=> (running && cnt == $past(cnt) + 1'b1));
    // R4: captured address is held through the conversion
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (running && !finish) |=> $stable(addr_lat));
endmodule

// File: rtl/sar_lane.sv
module sar_lane
    import dual_sar_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  sample_t sample,
    output sample_t result
);
    logic [DATA_W-1:0] held;
    logic [DATA_W-1:0] code;
    logic [DATA_W-1:0] trial_mask;
    logic [DATA_W-1:0] trial;

    assign trial  = code | trial_mask;
    assign result = from_offset(code);

    always_ff @(posedge clk) begin
        if (rst) begin
            held       <= '0;
            code       <= '0;
            trial_mask <= '0;
        end else if (load) begin
            held       <= to_offset(sample);
            code       <= '0;
            trial_mask <= SIGN_BIT;
        end else if (trial_mask != '0) begin
            if (trial <= held)
                code <= trial;
            trial_mask <= trial_mask >> 1;
        end
    end

    // R5: one bit decided per cycle, walking from MSB down
    p_mask_walk_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && trial_mask != '0) |=> (trial_mask == ($past(trial_mask) >> 1)));
    p_mask_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(trial_mask));
    // R3: held sample only changes on a load
    p_held_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(held));
endmodule

// File: rtl/result_bank.sv
module result_bank
    import dual_sar_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr,
    input  addr_t   wr_addr,
    input  pair_t   wr_pair,
    input  logic    cs_n,
    input  logic    rd_n,
    input  addr_t   addr,
    output sample_t dout,
    output logic    dout_oe
);
    pair_t [N_ADDR-1:0] slots;
    lane_e              sel;
    logic               rd_q;
    addr_t              addr_q;
    logic               rd_rise;
    logic               ptr_clear;

    assign rd_rise   = rd_n & ~rd_q;
    assign ptr_clear = cs_n | (addr != addr_q);
    assign dout_oe   = ~cs_n & ~rd_n;
    assign dout      = dout_oe ? pick_lane(slots[addr], sel) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            slots  <= '0;
            sel    <= SEL_A;
            rd_q   <= 1'b1;
            addr_q <= '0;
        end else begin
            rd_q   <= rd_n;
            addr_q <= addr;
            if (wr)
                slots[wr_addr] <= wr_pair;
            if (ptr_clear)
                sel <= SEL_A;
            else if (rd_rise)
                sel <= lane_e'(~sel);
        end
    end

    // R8: chip select high clears the pointer
    p_cs_clear_r8: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (sel == SEL_A));
    // R7: pointer flips after each strobe with the address steady
    p_toggle_r7: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && rd_rise && addr == addr_q) |=> (sel != $past(sel)));
    // R4: slots hold unless written
    p_slot_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(slots));
endmodule

// File: rtl/dual_sar_core.sv
module dual_sar_core
    import dual_sar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] samp_a,
    input  logic [DATA_W-1:0] samp_b,
    output logic              busy,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    logic    begin_conv;
    logic    finish;
    addr_t   addr_lat;
    sample_t [N_LANE-1:0] lane_in;
    sample_t [N_LANE-1:0] lane_out;
    pair_t   done_pair;
    sample_t bus_word;

    assign lane_in[0] = sample_t'(samp_a);
    assign lane_in[1] = sample_t'(samp_b);
    assign done_pair  = '{ch_a: lane_out[0], ch_b: lane_out[1]};
    assign dout       = bus_word;

    sar_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_n    (start_n),
        .addr       (addr),
        .busy       (busy),
        .begin_conv (begin_conv),
        .finish     (finish),
        .addr_lat   (addr_lat)
    );

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        sar_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .load   (begin_conv),
            .sample (lane_in[g]),
            .result (lane_out[g])
        );
    end

    result_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (finish),
        .wr_addr (addr_lat),
        .wr_pair (done_pair),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .addr    (addr),
        .dout    (bus_word),
        .dout_oe (dout_oe)
    );

    // R6: the bus never drives a nonzero word while disabled
    p_bus_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> (dout == '0));
endmodule

// File: tb/dual_sar_core_tb.sv
module dual_sar_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_n = 1'b1;
    logic [0:0]   addr = 1'b0;
    logic         cs_n = 1'b1;
    logic         rd_n = 1'b1;
    logic [W-1:0] samp_a = '0;
    logic [W-1:0] samp_b = '0;
    logic         busy;
    logic [W-1:0] dout;
    logic         dout_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done_run = 1'b0;
    logic [W-1:0] exp_a [2];
    logic [W-1:0] exp_b [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_sar_core u_dut (
        .clk(clk), .rst(rst), .start_n(start_n), .addr(addr),
        .cs_n(cs_n), .rd_n(rd_n), .samp_a(samp_a), .samp_b(samp_b),
        .busy(busy), .dout(dout), .dout_oe(dout_oe)
    );

    function automatic logic [W-1:0] model_code(logic [W-1:0] s);
        return s;   // two's complement result equals the sample
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic convert(logic [W-1:0] a, logic [W-1:0] b, logic ad, bit disturb);
        bit held_ok = 1'b1;
        @(negedge clk);
        addr = ad; samp_a = a; samp_b = b; start_n = 1'b0;
        #1 check("R1 busy on strobe", busy, 1);
        @(negedge clk);
        start_n = 1'b1;
        samp_a = $urandom(); samp_b = $urandom(); addr = ~ad;   // R3 R4 capture edge
        for (int i = 1; i <= 16; i++) begin
            if (i > 1) @(negedge clk);
            if (disturb) begin
                if (i == 5) start_n = 1'b0;
                if (i == 6) start_n = 1'b1;
                cs_n = (i < 14) ? 1'b0 : 1'b1;   // R10 bus activity
                rd_n = (i < 14) ? logic'(i % 2) : 1'b1;
            end
            #1 if (busy !== 1'b1) held_ok = 1'b0;
        end
        check("R2 busy held sixteen cycles", held_ok, 1);
        @(negedge clk);
        #1 check("R2 busy low after sixteenth edge", busy, 0);
        if (disturb) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                #1 check("R9 ignored strobe starts nothing", busy, 0);
            end
        end
        exp_a[ad] = model_code(a);
        exp_b[ad] = model_code(b);
    endtask

    task automatic read_pair(logic ad, string req);
        @(negedge clk);
        addr = ad; cs_n = 1'b0; rd_n = 1'b0;
        #1 check({req, " R6 oe on read"}, dout_oe, 1);
        check({req, " R7 lane A first"}, dout, exp_a[ad]);
        @(negedge clk);
        rd_n = 1'b1;
        #1 check({req, " R6 oe off between strobes"}, dout_oe, 0);
        @(negedge clk);
        rd_n = 1'b0;
        #1 check({req, " R7 lane B second"}, dout, exp_b[ad]);
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        rd_n = 1'b0;
        #1 check({req, " R7 wraps to A"}, dout, exp_a[ad]);
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;   // R8: next read must restart at A
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done_run) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        exp_a[0] = '0; exp_b[0] = '0; exp_a[1] = '0; exp_b[1] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 check("R11 busy after reset", busy, 0);
        check("R11 oe after reset", dout_oe, 0);
        read_pair(1'b0, "R11 empty slot0");
        read_pair(1'b1, "R11 empty slot1");

        // directed corners, with mid-conversion strobe and bus activity
        convert(12'h800, 12'h7FF, 1'b0, 1'b1);
        read_pair(1'b0, "R5 extremes R3");
        convert(12'hFFF, 12'h000, 1'b1, 1'b0);
        read_pair(1'b1, "R4 slot1");
        read_pair(1'b0, "R4 slot0 kept");

        // R6: only both-low enables the bus
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b1;
        #1 check("R6 cs only", dout_oe, 0);
        check("R6 dout zero", dout, 0);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
        #1 check("R6 rd only", dout_oe, 0);
        check("R6 dout zero rd only", dout, 0);
        @(negedge clk); rd_n = 1'b1;

        // R8: address change between strobes returns to lane A
        @(negedge clk); addr = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
        #1 check("R8 pre A", dout, exp_a[0]);
        @(negedge clk); rd_n = 1'b1;
        @(negedge clk); addr = 1'b1;
        @(negedge clk); rd_n = 1'b0;
        #1 check("R8 addr change gives A", dout, exp_a[1]);
        @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;

        // constrained random conversions
        for (int n = 0; n < 12; n++) begin
            logic [W-1:0] ra = $urandom();
            logic [W-1:0] rb = $urandom();
            logic         rad = logic'($urandom() % 2);
            convert(ra, rb, rad, (n % 4) == 0);
            read_pair(rad, "R5 random");
            read_pair(~rad, "R4 random other");
        end

        done_run = 1'b1;
        finish_run();
    end
endmodule